// File: doc/BRIEF.md
# Transactional Line-Tracking Data Cache

This block is a small, fully associative per-core data cache that runs hardware transactions. Inside a transaction, a load marks its line as part of the read set. A store keeps its new value next to the last committed value and marks the line as written. Neither is seen outside the core until the transaction ends. At commit the cache takes the shared bus and sends each written address as a write broadcast. Each broadcast also writes the value to backing memory. It then makes all of its lines ordinary again.

The cache watches the write broadcasts of other cores. Conflicts are compared at line granularity, where a line is a word address shifted right by `LINE_BITS`. If a broadcast names a line that the running transaction has touched, the transaction aborts and the written words return to their pre-transaction values. A transactional access that needs a new entry when every entry already holds transactional state also aborts.

Stores outside a transaction write through to memory and broadcast in the same way, so transactions on other cores see them. Each entry holds one word. Refills go through a bus read that reads backing memory, and the data returns one cycle later.

Top module: `txn_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `tx_active`, `abort_pulse`, `resp_valid`, `bus_req`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: A load (op 0) returns the backing-memory word. On a miss the cache raises `bus_req`. In the granted cycle it drives `bus_out_valid` with kind 0 (read) and `mem_rd_en`, and it answers two cycles after the grant. A hit answers one cycle after acceptance and makes no bus read.
- R3: A store (op 1) made with no transaction running drives `mem_wr_en` in its granted cycle, together with a kind 1 (write) broadcast of the same address. A later load returns the new value.
- R4: While `tx_active` is 1, every load and store is transactional. A store keeps its value locally, and a later load in the same transaction returns it. Memory is not written and no write broadcast is sent until commit.
- R5: End (op 3) with a transaction running waits for the grant. It then makes one write broadcast and one memory write per word written in the transaction, clears `tx_active` and gives `resp_valid`.
- R6: A snooped broadcast (`snoop_valid` with `bus_gnt` low) aborts the running transaction when its line address matches any line the transaction has touched. Two different words in one line count as a match. A broadcast to another line has no effect.
- R7: `abort_pulse` is high for exactly one cycle, never together with `resp_valid`, and `tx_active` is 0 in that cycle. After an abort, words stored in the transaction read back their pre-transaction values.
- R8: A transactional load or store that misses while every entry holds transactional state aborts the transaction.
- R9: After an abort, a load or store with `req_tx` set completes with `resp_valid`, read data 0 and no effect until the next begin (op 2). An end with no transaction running completes with no effect.
- R10: A snoop that arrives in the same cycle as this cache's `bus_gnt` is ignored, so a pending commit goes ahead. A snoop while the commit still waits for the grant aborts it and leaves memory unchanged.
- R11: A snoop whose full address equals a cached word invalidates it, so the next load of that word fetches from memory again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request strobe |
| req_op | input | 2 | 0 load, 1 store, 2 begin, 3 end |
| req_tx | input | 1 | Core believes the access is transactional |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Cache can accept a request |
| resp_valid | output | 1 | Request completed |
| resp_rdata | output | DW | Load data |
| abort_pulse | output | 1 | One-cycle transaction abort |
| tx_active | output | 1 | Transaction running |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_out_valid | output | 1 | Own broadcast valid |
| bus_out_kind | output | 1 | 0 read, 1 write |
| bus_out_addr | output | AW | Broadcast address |
| snoop_valid | input | 1 | Another core's write broadcast |
| snoop_addr | input | AW | Snooped address |
| mem_rd_en | output | 1 | Backing-memory read |
| mem_wr_en | output | 1 | Backing-memory write |
| mem_addr | output | AW | Backing-memory address |
| mem_wdata | output | DW | Backing-memory write data |
| mem_rdata | input | DW | Read data, one cycle after `mem_rd_en` |

## Verification
The assertions check the following on every cycle:
- the abort pulse lasts one cycle and never comes with a response;
- a snooped line conflict or a full cache is followed by an abort;
- the cache broadcasts only while granted;
- memory writes appear only as granted write broadcasts and never during a running transaction;
- a refill completes two cycles after its read;
- tags stay unique.

Only the bench scenarios can show the data-level behaviours: that the values read back are the ones memory holds, and that written words return to their old values after an abort. They also show that a false-sharing snoop aborts while a snoop to the neighbouring line does not, that a grant-cycle tie lets the commit win, and that requests after an abort have no effect.

// File: rtl/txn_cache_pkg.sv
// Package: shared encodings for the transactional cache.
// Assumes: request opcodes and bus kinds are fixed by the port contract.
package txn_cache_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_BEGIN = 2'd2,
        OP_END   = 2'd3
    } tc_op_e;

    typedef enum logic {
        BUS_READ  = 1'b0,
        BUS_WRITE = 1'b1
    } tc_bus_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_BUS,
        ST_FILL,
        ST_WT_BUS,
        ST_COMMIT
    } tc_state_e;
endpackage

// File: rtl/txn_cache_lookup.sv
// Module: tag match and victim choice over the fully associative array.
// Assumes: an invalid entry never carries the transactional flag; the
// lowest-numbered invalid entry is preferred, then the lowest non-transactional one.
module txn_cache_lookup #(
    parameter int ENTRIES = 4,
    parameter int AW      = 8,
    parameter int IW      = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ENTRIES-1:0]          valid,
    input  logic [ENTRIES-1:0]          trans,
    input  logic [ENTRIES-1:0][AW-1:0]  tags,
    input  logic [AW-1:0]               addr,
    output logic                        hit,
    output logic [IW-1:0]               hit_idx,
    output logic                        vict_ok,
    output logic [IW-1:0]               vict_idx
);
    logic [ENTRIES-1:0] hit_vec;

    // Per-entry exact tag comparison.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == addr);
    end

    // Encode the matching entry.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end
    assign hit = |hit_vec;

    // Pick a replaceable entry: invalid first, else non-transactional.
    always_comb begin
        vict_ok  = 1'b0;
        vict_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!trans[i]) begin
                vict_ok  = 1'b1;
                vict_idx = IW'(i);
            end
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) vict_idx = IW'(i);
        end
    end

    // R2: an address is cached at most once
    unique_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/txn_cache_snoop.sv
// Module: compares a snooped broadcast against the cached lines.
// Assumes: a line is the word address shifted right by LINE_BITS.
module txn_cache_snoop #(
    parameter int ENTRIES   = 4,
    parameter int AW        = 8,
    parameter int LINE_BITS = 1
) (
    input  logic [ENTRIES-1:0]          valid,
    input  logic [ENTRIES-1:0]          trans,
    input  logic [ENTRIES-1:0][AW-1:0]  tags,
    input  logic [AW-1:0]               snoop_addr,
    output logic                        line_conflict,
    output logic [ENTRIES-1:0]          inv_vec
);
    logic [ENTRIES-1:0] line_vec;

    // Line-level and word-level comparisons per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_snp
        assign line_vec[g] = valid[g] && trans[g] &&
                             (tags[g][AW-1:LINE_BITS] == snoop_addr[AW-1:LINE_BITS]);
        assign inv_vec[g]  = valid[g] && (tags[g] == snoop_addr);
    end

    assign line_conflict = |line_vec;
endmodule

// File: rtl/txn_cache.sv
// Module: transactional data cache top. Holds the entry array and the
// controller for refills, write-through, commit walk and abort rollback.
// Assumes: one request outstanding, bus grant held while bus_req stays high,
// memory read data valid one cycle after mem_rd_en.
module txn_cache
    import txn_cache_pkg::*;
#(
    parameter int ENTRIES   = 4,
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int LINE_BITS = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          req_tx,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          resp_valid,
    output logic [DW-1:0] resp_rdata,
    output logic          abort_pulse,
    output logic          tx_active,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_out_valid,
    output logic          bus_out_kind,
    output logic [AW-1:0] bus_out_addr,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    logic [ENTRIES-1:0]          v_q, tr_q, md_q;
    logic [ENTRIES-1:0][AW-1:0]  tag_q;
    logic [ENTRIES-1:0][DW-1:0]  cur_q, old_q;
    tc_state_e                   state_q;
    logic [AW-1:0]               addr_q;
    logic [DW-1:0]               wdata_q, rdata_q;
    logic                        store_q, txop_q, alloc_q, tx_q, resp_q, abort_q;
    logic [IW-1:0]               vict_q, walk_q;

    logic [AW-1:0]      look_addr;
    logic               lk_hit, lk_vict_ok, snp_conflict;
    logic [IW-1:0]      lk_hit_idx, lk_vict_idx;
    logic [ENTRIES-1:0] snp_inv;
    tc_op_e             op;
    logic               is_mem, snoop_act, snoop_abort, cap_abort, abort_now, emit;

    assign op        = tc_op_e'(req_op);
    assign look_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
    assign is_mem    = (op == OP_LOAD) || (op == OP_STORE);

    txn_cache_lookup #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_lookup (
        .clk(clk), .rst_n(rst_n), .valid(v_q), .trans(tr_q), .tags(tag_q),
        .addr(look_addr), .hit(lk_hit), .hit_idx(lk_hit_idx),
        .vict_ok(lk_vict_ok), .vict_idx(lk_vict_idx)
    );

    txn_cache_snoop #(.ENTRIES(ENTRIES), .AW(AW), .LINE_BITS(LINE_BITS)) u_snoop (
        .valid(v_q), .trans(tr_q), .tags(tag_q), .snoop_addr(snoop_addr),
        .line_conflict(snp_conflict), .inv_vec(snp_inv)
    );

    // Abort sources: snooped line conflict (lost unless granted) and capacity.
    assign snoop_act   = snoop_valid && !bus_gnt;
    assign snoop_abort = snoop_act && tx_q && snp_conflict;
    assign cap_abort   = (state_q == ST_IDLE) && req_valid && tx_q && is_mem &&
                         !lk_hit && !lk_vict_ok;
    assign abort_now   = snoop_abort || cap_abort;

    // Bus and memory drive for refill, write-through and commit walk.
    assign emit          = v_q[walk_q] && tr_q[walk_q] && md_q[walk_q];
    assign bus_req       = (state_q == ST_RD_BUS) || (state_q == ST_WT_BUS) ||
                           (state_q == ST_COMMIT);
    assign mem_rd_en     = (state_q == ST_RD_BUS) && bus_gnt;
    assign mem_wr_en     = bus_gnt && ((state_q == ST_WT_BUS) ||
                                       ((state_q == ST_COMMIT) && emit));
    assign bus_out_valid = mem_rd_en || mem_wr_en;
    assign bus_out_kind  = (state_q == ST_RD_BUS) ? BUS_READ : BUS_WRITE;
    assign bus_out_addr  = (state_q == ST_COMMIT) ? tag_q[walk_q] : addr_q;
    assign mem_addr      = bus_out_addr;
    assign mem_wdata     = (state_q == ST_COMMIT) ? cur_q[walk_q] : wdata_q;

    assign req_ready   = (state_q == ST_IDLE);
    assign resp_valid  = resp_q;
    assign resp_rdata  = rdata_q;
    assign abort_pulse = abort_q;
    assign tx_active   = tx_q;

    // Controller and entry array update, with rollback and snoop invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0; tr_q <= '0; md_q <= '0;
            tag_q <= '0; cur_q <= '0; old_q <= '0;
            state_q <= ST_IDLE; addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
            store_q <= 1'b0; txop_q <= 1'b0; alloc_q <= 1'b0; tx_q <= 1'b0;
            resp_q <= 1'b0; abort_q <= 1'b0; vict_q <= '0; walk_q <= '0;
        end else begin
            resp_q  <= 1'b0;
            abort_q <= 1'b0;
            if (abort_now) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (tr_q[i] && md_q[i]) cur_q[i] <= old_q[i];
                    tr_q[i] <= 1'b0;
                    md_q[i] <= 1'b0;
                end
                tx_q    <= 1'b0;
                state_q <= ST_IDLE;
                abort_q <= 1'b1;
            end else begin
                case (state_q)
                    ST_IDLE: if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        store_q <= (op == OP_STORE);
                        txop_q  <= tx_q;
                        vict_q  <= lk_vict_idx;
                        if (is_mem && req_tx && !tx_q) begin
                            resp_q  <= 1'b1;
                            rdata_q <= '0;
                        end else begin
                            case (op)
                                OP_BEGIN: begin
                                    tx_q   <= 1'b1;
                                    resp_q <= 1'b1;
                                end
                                OP_END: begin
                                    if (tx_q) begin
                                        state_q <= ST_COMMIT;
                                        walk_q  <= '0;
                                    end else begin
                                        resp_q <= 1'b1;
                                    end
                                end
                                OP_LOAD: begin
                                    if (lk_hit) begin
                                        resp_q  <= 1'b1;
                                        rdata_q <= cur_q[lk_hit_idx];
                                        if (tx_q) tr_q[lk_hit_idx] <= 1'b1;
                                    end else begin
                                        alloc_q <= lk_vict_ok;
                                        state_q <= ST_RD_BUS;
                                    end
                                end
                                default: begin
                                    if (!tx_q) begin
                                        state_q <= ST_WT_BUS;
                                    end else if (lk_hit) begin
                                        cur_q[lk_hit_idx] <= req_wdata;
                                        tr_q[lk_hit_idx]  <= 1'b1;
                                        md_q[lk_hit_idx]  <= 1'b1;
                                        resp_q            <= 1'b1;
                                    end else begin
                                        alloc_q <= 1'b1;
                                        state_q <= ST_RD_BUS;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_RD_BUS: if (bus_gnt) state_q <= ST_FILL;
                    ST_FILL: begin
                        resp_q  <= 1'b1;
                        rdata_q <= mem_rdata;
                        if (alloc_q) begin
                            v_q[vict_q]   <= 1'b1;
                            tag_q[vict_q] <= addr_q;
                            old_q[vict_q] <= mem_rdata;
                            cur_q[vict_q] <= store_q ? wdata_q : mem_rdata;
                            tr_q[vict_q]  <= txop_q;
                            md_q[vict_q]  <= store_q;
                        end
                        state_q <= ST_IDLE;
                    end
                    ST_WT_BUS: if (bus_gnt) begin
                        if (lk_hit) begin
                            cur_q[lk_hit_idx] <= wdata_q;
                            old_q[lk_hit_idx] <= wdata_q;
                        end
                        resp_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                    ST_COMMIT: if (bus_gnt) begin
                        walk_q <= walk_q + 1'b1;
                        if (walk_q == LAST) begin
                            for (int i = 0; i < ENTRIES; i++) begin
                                if (tr_q[i] && md_q[i]) old_q[i] <= cur_q[i];
                                tr_q[i] <= 1'b0;
                                md_q[i] <= 1'b0;
                            end
                            tx_q    <= 1'b0;
                            resp_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
            for (int i = 0; i < ENTRIES; i++) begin
                if (snoop_act && snp_inv[i]) v_q[i] <= 1'b0;
            end
        end
    end

    // R7
    abort_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);
    // R7
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!resp_valid && !tx_active));
    // R6
    snoop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && !bus_gnt && tx_active && snp_conflict) |=> abort_pulse);
    // R8
    capacity_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && tx_active && !req_op[1] && !lk_hit && !lk_vict_ok)
        |=> abort_pulse);
    // R2
    bus_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid |-> bus_gnt);
    // R3
    wr_broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (bus_out_valid && bus_out_kind == BUS_WRITE));
    // R4
    no_spec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && state_q != ST_COMMIT) |-> !mem_wr_en);
    // R2
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 (resp_valid || abort_pulse));
endmodule

// File: tb/txn_cache_bench.sv
// Bench: directed sweeps over a 4-entry, 2-word-line configuration with an
// arithmetic memory image f(a) = 3a + 1 and a single bus arbiter.
module txn_cache_bench;
    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic          req_tx = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, abort_pulse, tx_active;
    logic [DW-1:0] resp_rdata;
    logic          bus_req, bus_gnt, bus_out_valid, bus_out_kind;
    logic [AW-1:0] bus_out_addr;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          gnt_en = 1'b1;

    logic [DW-1:0] mem [256];
    int nchk = 0, nerr = 0, cyc = 0, rd_bc = 0, wr_bc = 0;
    logic [AW-1:0] last_bc = '0;

    always #10 clk = ~clk;

    assign bus_gnt = bus_req & gnt_en;

    txn_cache u_txn_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_tx(req_tx), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .abort_pulse(abort_pulse), .tx_active(tx_active), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_out_valid(bus_out_valid), .bus_out_kind(bus_out_kind),
        .bus_out_addr(bus_out_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Backing memory and bus monitor.
    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (bus_out_valid && !bus_out_kind) rd_bc <= rd_bc + 1;
        if (bus_out_valid && bus_out_kind) begin
            wr_bc   <= wr_bc + 1;
            last_bc <= bus_out_addr;
        end
    end

    function automatic logic [7:0] f(input int a);
        return 8'((a * 3 + 1) & 255);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output logic got_r, output logic got_a, output logic [7:0] rd);
        got_r = 1'b0; got_a = 1'b0; rd = '0;
        for (int k = 0; k < 60; k++) begin
            if (resp_valid || abort_pulse) begin
                got_r = resp_valid; got_a = abort_pulse; rd = resp_rdata;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic tx, input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_tx = tx;
        req_addr = 8'(a); req_wdata = 8'(d);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] op, input logic tx, input int a, input int d,
                         output logic got_r, output logic got_a, output logic [7:0] rd);
        issue(op, tx, a, d);
        wait_done(got_r, got_a, rd);
    endtask

    task automatic snoop_one(input int a);
        snoop_valid = 1'b1; snoop_addr = 8'(a);
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                nchk++; nerr++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
                $display("Result: errors=%0d of %0d checks", nerr, nchk);
                $finish;
            end
        end
    end

    initial begin
        logic r, ab;
        logic [7:0] d;
        int base;
        for (int i = 0; i < 256; i++) mem[i] = f(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 tx_active", int'(tx_active), 0);
        chk("R1 quiet", int'({abort_pulse, resp_valid, bus_req, mem_rd_en, mem_wr_en}), 0);

        // R2: sweep of non-transactional loads, misses then a hit
        for (int a = 0; a < 16; a++) begin
            do_op(2'd0, 1'b0, a, 0, r, ab, d);
            chk("R2 load data", int'(d), int'(f(a)));
        end
        chk("R2 refill reads", rd_bc, 16);
        base = rd_bc;
        do_op(2'd0, 1'b0, 3, 0, r, ab, d);
        chk("R2 hit data", int'(d), int'(f(3)));
        chk("R2 hit no bus read", rd_bc, base);

        // R11: exact-word snoop invalidates, refetch sees the new memory value
        mem[2] = 8'h5C;
        @(negedge clk);
        snoop_one(2);
        do_op(2'd0, 1'b0, 2, 0, r, ab, d);
        chk("R11 refetch", int'(d), 8'h5C);

        // R3: write-through store
        base = wr_bc;
        do_op(2'd1, 1'b0, 5, 8'hA5, r, ab, d);
        chk("R3 broadcast", wr_bc, base + 1);
        chk("R3 broadcast addr", int'(last_bc), 5);
        chk("R3 memory", int'(mem[5]), 8'hA5);
        do_op(2'd0, 1'b0, 5, 0, r, ab, d);
        chk("R3 readback", int'(d), 8'hA5);

        // R4: speculative store stays local
        do_op(2'd2, 1'b0, 0, 0, r, ab, d);
        chk("R4 tx_active", int'(tx_active), 1);
        base = wr_bc;
        do_op(2'd1, 1'b1, 8'h20, 8'h11, r, ab, d);
        chk("R4 no broadcast", wr_bc, base);
        chk("R4 memory old", int'(mem[8'h20]), int'(f(8'h20)));
        do_op(2'd0, 1'b1, 8'h20, 0, r, ab, d);
        chk("R4 own value", int'(d), 8'h11);

        // R5: commit publishes the write
        do_op(2'd3, 1'b1, 0, 0, r, ab, d);
        chk("R5 resp", int'({r, ab}), 2);
        chk("R5 broadcast", wr_bc, base + 1);
        chk("R5 broadcast addr", int'(last_bc), 8'h20);
        chk("R5 memory", int'(mem[8'h20]), 8'h11);
        chk("R5 tx cleared", int'(tx_active), 0);

        // R6 / R7: false-sharing snoop aborts and rolls back
        do_op(2'd2, 1'b0, 0, 0, r, ab, d);
        do_op(2'd0, 1'b1, 8'h30, 0, r, ab, d);
        chk("R6 tx load", int'(d), int'(f(8'h30)));
        do_op(2'd0, 1'b1, 8'h40, 0, r, ab, d);
        do_op(2'd1, 1'b1, 8'h40, 8'h77, r, ab, d);
        do_op(2'd1, 1'b1, 8'h41, 8'h78, r, ab, d);
        @(negedge clk);
        snoop_one(8'h31);
        chk("R6 false-sharing abort", int'(abort_pulse), 1);
        chk("R7 tx cleared on abort", int'(tx_active), 0);
        @(negedge clk);
        chk("R7 single pulse", int'(abort_pulse), 0);

        // R9: transactional requests after abort have no effect
        do_op(2'd1, 1'b1, 8'h40, 8'h99, r, ab, d);
        chk("R9 store completes", int'({r, ab}), 2);
        do_op(2'd0, 1'b1, 8'h40, 0, r, ab, d);
        chk("R9 load zero", int'(d), 0);
        do_op(2'd3, 1'b1, 0, 0, r, ab, d);
        chk("R9 end completes", int'({r, ab}), 2);
        do_op(2'd0, 1'b0, 8'h40, 0, r, ab, d);
        chk("R7 hit word reverted", int'(d), int'(f(8'h40)));
        do_op(2'd0, 1'b0, 8'h41, 0, r, ab, d);
        chk("R7 miss word reverted", int'(d), int'(f(8'h41)));
        chk("R9 memory untouched", int'(mem[8'h40]), int'(f(8'h40)));

        // R6: snoop of a neighbouring line is harmless
        do_op(2'd2, 1'b0, 0, 0, r, ab, d);
        do_op(2'd0, 1'b1, 8'h50, 0, r, ab, d);
        @(negedge clk);
        snoop_one(8'h52);
        chk("R6 no abort other line", int'(abort_pulse), 0);
        do_op(2'd3, 1'b1, 0, 0, r, ab, d);
        chk("R6 commit after harmless snoop", int'({r, ab}), 2);

        // R8: capacity overflow
        do_op(2'd2, 1'b0, 0, 0, r, ab, d);
        for (int k = 0; k < 4; k++) begin
            do_op(2'd0, 1'b1, 8'h60 + 2 * k, 0, r, ab, d);
            chk("R8 fits", int'(d), int'(f(8'h60 + 2 * k)));
        end
        do_op(2'd0, 1'b1, 8'h68, 0, r, ab, d);
        chk("R8 overflow abort", int'({r, ab}), 1);
        chk("R8 tx cleared", int'(tx_active), 0);

        // R10: snoop in the grant cycle loses to the commit
        do_op(2'd2, 1'b0, 0, 0, r, ab, d);
        do_op(2'd1, 1'b1, 8'h80, 8'h5A, r, ab, d);
        gnt_en = 1'b0;
        issue(2'd3, 1'b1, 0, 0);
        chk("R10 waiting for bus", int'(bus_req), 1);
        gnt_en = 1'b1;
        snoop_one(8'h80);
        wait_done(r, ab, d);
        chk("R10 commit wins", int'({r, ab}), 2);
        chk("R10 memory committed", int'(mem[8'h80]), 8'h5A);

        // R10: snoop before the grant aborts the commit
        do_op(2'd2, 1'b0, 0, 0, r, ab, d);
        do_op(2'd1, 1'b1, 8'h90, 8'h01, r, ab, d);
        gnt_en = 1'b0;
        issue(2'd3, 1'b1, 0, 0);
        snoop_one(8'h90);
        chk("R10 commit loses", int'(abort_pulse), 1);
        gnt_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 memory unchanged", int'(mem[8'h90]), int'(f(8'h90)));

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule